// File: doc/BRIEF.md
# Binary Arithmetic Encoding Engine

This block is the back end of a context-adaptive entropy coder. It takes one bin at a time under a valid/ready handshake. Each bin is tagged regular, bypass or terminate. A regular bin comes with the probability state and most-probable value of its context. It also comes with the four candidate least-probable sub-ranges for that state and the state that follows a least-probable outcome. The engine selects one sub-range using two bits of its current range. It then narrows the interval and returns the updated state and most-probable value to the context store one cycle after it accepts the bin.

Bypass bins double the low register and skip the context update. Terminate bins shave two from the range. A terminate bin of 1 closes the segment: the engine flushes the low register and then starts over from its initial interval. All three kinds feed a common renormalizer, which shifts one position per cycle. A bit generator resolves carry-dependent outstanding bits and drives the coded bits out serially, one per clock.

Top module: `bin_arith_encoder`

## Requirements
- R1: After reset the interval is range 510 and low 0. `in_ready` is high, and `out_valid` and `ctx_wr_valid` are low.
- R2: `in_kind` encodings are 2'b00 regular, 2'b01 bypass, and 2'b10 or 2'b11 terminate. A regular bin equal to `in_mps` sets the range to range minus the selected sub-range. The selected sub-range is byte `range[7:6]` of `in_lps_row`, with byte q at bits [8q+7:8q]. Low is left unchanged. The cycle after acceptance, `ctx_wr_valid` is high with the state incremented, saturating at 62, and with the most-probable value unchanged.
- R3: A regular bin differing from `in_mps` adds (range minus sub-range) to low and sets the range to the sub-range. The written-back state is `in_lps_next`. The most-probable value is inverted only when `in_state` is 0.
- R4: While the range is below 256, each cycle does one step and then doubles both range and low. If low < 256, the step emits a determined 0. If low ≥ 512, it emits a determined 1 and subtracts 512. Otherwise it subtracts 256 and counts one outstanding bit.
- R5: A determined bit b is followed on the output by one copy of the inverse of b per outstanding bit. The outstanding count then returns to zero.
- R6: The first determined bit of each segment is not output. Its outstanding followers still are.
- R7: A bypass bin doubles low and adds the range when the bin is 1. Then: if low ≥ 1024, it emits 1 and subtracts 1024; if low < 512, it emits 0; otherwise it subtracts 512 and counts one outstanding bit. The range is unchanged and there is no context write.
- R8: A terminate bin of 0 subtracts 2 from the range, leaves low unchanged, renormalizes, and produces no context write.
- R9: A terminate bin of 1 adds (range − 2) to low and sets the range to 2, then renormalizes. It then emits low[9] as a determined bit, followed by the raw bits low[8] and 1. Finally it restores range 510, low 0, no outstanding bits and first-bit suppression.
- R10: `in_ready` is low in the cycle after any accepted bin. It stays low until the renormalization or flush work for that bin is done.
- R11: Coded bits leave one per cycle, with `out_bit` qualified by `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bin offered |
| in_ready | output | 1 | Engine can take a bin |
| in_kind | input | 2 | 00 regular, 01 bypass, 1x terminate |
| in_bin | input | 1 | Bin value |
| in_state | input | STATE_W | Probability state of the context |
| in_mps | input | 1 | Most-probable value of the context |
| in_lps_row | input | 4*LPS_W | Four least-probable sub-ranges for the state, indexed by range[7:6] |
| in_lps_next | input | STATE_W | State after a least-probable outcome |
| ctx_wr_valid | output | 1 | Context write-back strobe |
| ctx_wr_state | output | STATE_W | Updated probability state |
| ctx_wr_mps | output | 1 | Updated most-probable value |
| out_valid | output | 1 | Coded bit present |
| out_bit | output | 1 | Coded bit |

## Verification
The bench runs long most-probable streams that reach state 62. It also sweeps every state with both bin values and both most-probable values, including the least-probable case at state 0. A wrong saturation or inversion rule shows up directly on the write-back port. Bypass runs near the interval midpoint build long chains of outstanding bits. If carries were resolved wrongly or followers were dropped, those chains would flip or lose bits. Every segment ends with a flush, and the bitstream is compared against an arithmetic model. That comparison catches a first bit that was not suppressed, a wrong flush tail, and a missing re-initialization, which would corrupt the following segment.

// File: rtl/bin_arith_encoder.sv
`timescale 1ns/1ps
module bin_arith_encoder #(
  parameter int STATE_W   = 6,
  parameter int LPS_W     = 8,
  parameter int MAX_STATE = 62,
  parameter int OUTST_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_kind,
  input  logic                 in_bin,
  input  logic [STATE_W-1:0]   in_state,
  input  logic                 in_mps,
  input  logic [4*LPS_W-1:0]   in_lps_row,
  input  logic [STATE_W-1:0]   in_lps_next,
  output logic                 ctx_wr_valid,
  output logic [STATE_W-1:0]   ctx_wr_state,
  output logic                 ctx_wr_mps,
  output logic                 out_valid,
  output logic                 out_bit
);

  localparam logic [8:0]  RANGE_INIT = 9'd510;
  localparam logic [11:0] LOW_QTR    = 12'd256;
  localparam logic [11:0] LOW_HALF   = 12'd512;
  localparam logic [11:0] LOW_FULL   = 12'd1024;

  typedef enum logic [2:0] {S_IDLE, S_NORM, S_BYP, S_FL_PUT, S_FL_B1, S_FL_B2} st_t;

  st_t                st_q, st_d;
  logic [8:0]         range_q, rng_d;
  logic [11:0]        low_q, low_d, lsub;
  logic [OUTST_W-1:0] outst_q, outst_d;
  logic               first_q, first_d, flush_q, flush_d;
  logic               em_head_q, em_hbit_q;
  logic [OUTST_W-1:0] em_tail_q;
  logic               step_put, put_b, put_raw, put_fire, em_idle;

  wire is_reg = (in_kind == 2'b00);
  wire is_byp = (in_kind == 2'b01);
  wire accept = in_valid && in_ready;

  wire [1:0]       qsel = range_q[7:6];
  wire [LPS_W-1:0] rlps = in_lps_row[qsel*LPS_W +: LPS_W];
  wire [8:0]       rmps = range_q - 9'(rlps);
  wire [8:0]       rtrm = range_q - 9'd2;

  assign in_ready  = (st_q == S_IDLE);
  assign out_valid = em_head_q || (em_tail_q != '0);
  assign out_bit   = em_head_q ? em_hbit_q : ~em_hbit_q;
  assign em_idle   = !out_valid;
  assign put_fire  = step_put && em_idle;

  always_comb begin
    st_d = st_q; rng_d = range_q; low_d = low_q; outst_d = outst_q;
    first_d = first_q; flush_d = flush_q;
    step_put = 1'b0; put_b = 1'b0; put_raw = 1'b0; lsub = low_q;
    unique case (st_q)
      S_IDLE: if (in_valid) begin
        if (is_reg) begin
          if (in_bin != in_mps) begin
            low_d = low_q + 12'(rmps);
            rng_d = 9'(rlps);
          end else begin
            rng_d = rmps;
          end
          st_d = S_NORM;
        end else if (is_byp) begin
          low_d = {low_q[10:0], 1'b0} + (in_bin ? 12'(range_q) : 12'd0);
          st_d  = S_BYP;
        end else begin
          rng_d = rtrm;
          st_d  = S_NORM;
          if (in_bin) begin
            low_d   = low_q + 12'(rtrm);
            rng_d   = 9'd2;
            flush_d = 1'b1;
          end
        end
      end
      S_NORM: begin
        if (range_q[8]) begin
          st_d = flush_q ? S_FL_PUT : S_IDLE;
        end else begin
          if (low_q < LOW_QTR) begin
            step_put = 1'b1;
          end else if (low_q >= LOW_HALF) begin
            step_put = 1'b1; put_b = 1'b1; lsub = low_q - LOW_HALF;
          end else begin
            outst_d = outst_q + 1'b1; lsub = low_q - LOW_QTR;
          end
          rng_d = {range_q[7:0], 1'b0};
          low_d = {lsub[10:0], 1'b0};
        end
      end
      S_BYP: begin
        st_d = S_IDLE;
        if (low_q >= LOW_FULL) begin
          step_put = 1'b1; put_b = 1'b1; low_d = low_q - LOW_FULL;
        end else if (low_q < LOW_HALF) begin
          step_put = 1'b1;
        end else begin
          outst_d = outst_q + 1'b1; low_d = low_q - LOW_HALF;
        end
      end
      S_FL_PUT: begin
        step_put = 1'b1; put_b = low_q[9]; st_d = S_FL_B1;
      end
      S_FL_B1: begin
        step_put = 1'b1; put_raw = 1'b1; put_b = low_q[8]; st_d = S_FL_B2;
      end
      S_FL_B2: begin
        step_put = 1'b1; put_raw = 1'b1; put_b = 1'b1; st_d = S_IDLE;
        rng_d = RANGE_INIT; low_d = '0; outst_d = '0; first_d = 1'b1; flush_d = 1'b0;
      end
      default: st_d = S_IDLE;
    endcase
    if (step_put && !em_idle) begin
      st_d = st_q; rng_d = range_q; low_d = low_q; outst_d = outst_q;
      first_d = first_q; flush_d = flush_q;
    end else if (step_put && !put_raw) begin
      outst_d = '0; first_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; range_q <= RANGE_INIT; low_q <= '0; outst_q <= '0;
      first_q <= 1'b1; flush_q <= 1'b0;
    end else begin
      st_q <= st_d; range_q <= rng_d; low_q <= low_d; outst_q <= outst_d;
      first_q <= first_d; flush_q <= flush_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      em_head_q <= 1'b0; em_hbit_q <= 1'b0; em_tail_q <= '0;
    end else if (put_fire) begin
      em_head_q <= put_raw || !first_q;
      em_hbit_q <= put_b;
      em_tail_q <= put_raw ? '0 : outst_q;
    end else if (em_head_q) begin
      em_head_q <= 1'b0;
    end else if (em_tail_q != '0) begin
      em_tail_q <= em_tail_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_wr_valid <= 1'b0; ctx_wr_state <= '0; ctx_wr_mps <= 1'b0;
    end else begin
      ctx_wr_valid <= accept && is_reg;
      if (accept && is_reg) begin
        if (in_bin != in_mps) begin
          ctx_wr_state <= in_lps_next;
          ctx_wr_mps   <= (in_state == '0) ? ~in_mps : in_mps;
        end else begin
          ctx_wr_state <= (in_state >= STATE_W'(MAX_STATE)) ? STATE_W'(MAX_STATE) : in_state + 1'b1;
          ctx_wr_mps   <= in_mps;
        end
      end
    end
  end

endmodule

module bin_arith_encoder_chk #(
  parameter int STATE_W   = 6,
  parameter int MAX_STATE = 62
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [1:0]         in_kind,
  input logic               in_bin,
  input logic [STATE_W-1:0] in_state,
  input logic               in_mps,
  input logic               ctx_wr_valid,
  input logic [STATE_W-1:0] ctx_wr_state,
  input logic               ctx_wr_mps,
  input logic               out_valid,
  input logic               out_bit,
  input logic [8:0]         range_q
);
  wire acc     = in_valid && in_ready;
  wire acc_reg = acc && (in_kind == 2'b00);

  a_r2_ctx_after_regular: assert property (@(posedge clk) disable iff (!rst_n)
    acc_reg |=> ctx_wr_valid);

  a_r7_no_ctx_other_kinds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_kind != 2'b00) |=> !ctx_wr_valid);

  a_r2_mps_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_reg && in_bin == in_mps) |=>
      (ctx_wr_mps == $past(in_mps)) &&
      (ctx_wr_state == (($past(in_state) >= STATE_W'(MAX_STATE)) ?
                        STATE_W'(MAX_STATE) : $past(in_state) + 1'b1)));

  a_r3_lps_zero_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_reg && in_bin != in_mps && in_state == '0) |=> (ctx_wr_mps != $past(in_mps)));

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);

  a_r4_range_normalized: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> range_q[8]);

  a_r11_bit_known: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_bit));
endmodule

bind bin_arith_encoder bin_arith_encoder_chk #(.STATE_W(STATE_W), .MAX_STATE(MAX_STATE)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
  .in_bin(in_bin), .in_state(in_state), .in_mps(in_mps), .ctx_wr_valid(ctx_wr_valid),
  .ctx_wr_state(ctx_wr_state), .ctx_wr_mps(ctx_wr_mps), .out_valid(out_valid),
  .out_bit(out_bit), .range_q(range_q)
);

// File: tb/bin_arith_encoder_tb.sv
`timescale 1ns/1ps
module bin_arith_encoder_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, in_bin, in_mps;
  logic        in_ready, ctx_wr_valid, ctx_wr_mps, out_valid, out_bit;
  logic [1:0]  in_kind;
  logic [5:0]  in_state, in_lps_next, ctx_wr_state;
  logic [31:0] in_lps_row;

  bin_arith_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_bin(in_bin), .in_state(in_state), .in_mps(in_mps), .in_lps_row(in_lps_row),
    .in_lps_next(in_lps_next), .ctx_wr_valid(ctx_wr_valid), .ctx_wr_state(ctx_wr_state),
    .ctx_wr_mps(ctx_wr_mps), .out_valid(out_valid), .out_bit(out_bit)
  );

  int checks = 0, fails = 0;
  bit exp_q[$];
  bit got_q[$];
  int m_rng = 510, m_low = 0, m_out = 0;
  bit m_first = 1'b1;

  always @(negedge clk) if (rst_n && out_valid) got_q.push_back(out_bit);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rl(int s, int q);
    return 6 + ((128 + 32*q) * (63 - s)) / 63;
  endfunction
  function automatic int lnext(int s);
    return (s == 0) ? 0 : s - 1 - s/16;
  endfunction
  function automatic logic [31:0] row_of(int s);
    logic [31:0] r;
    for (int q = 0; q < 4; q++) r[q*8 +: 8] = 8'(rl(s, q));
    return r;
  endfunction

  task automatic m_put(bit b);
    if (m_first) m_first = 1'b0; else exp_q.push_back(b);
    while (m_out > 0) begin exp_q.push_back(!b); m_out--; end
  endtask

  task automatic m_renorm();
    while (m_rng < 256) begin
      if (m_low < 256) m_put(1'b0);
      else if (m_low >= 512) begin m_low -= 512; m_put(1'b1); end
      else begin m_low -= 256; m_out++; end
      m_rng = m_rng * 2; m_low = m_low * 2;
    end
  endtask

  task automatic send(logic [1:0] kind, bit b, int s, bit m, output int ns, output bit nm);
    int rlps;
    ns = s; nm = m;
    if (kind == 2'b00) begin
      rlps = rl(s, (m_rng >> 6) & 3);
      if (b != m) begin
        m_low += m_rng - rlps; m_rng = rlps;
        ns = lnext(s); nm = (s == 0) ? !m : m;
      end else begin
        m_rng -= rlps; ns = (s >= 62) ? 62 : s + 1;
      end
      m_renorm();
    end else if (kind == 2'b01) begin
      m_low = m_low * 2 + (b ? m_rng : 0);
      if (m_low >= 1024) begin m_low -= 1024; m_put(1'b1); end
      else if (m_low < 512) m_put(1'b0);
      else begin m_low -= 512; m_out++; end
    end else begin
      m_rng -= 2;
      if (b) begin
        m_low += m_rng; m_rng = 2; m_renorm();
        m_put(bit'((m_low >> 9) & 1));
        exp_q.push_back(bit'((m_low >> 8) & 1));
        exp_q.push_back(1'b1);
        m_rng = 510; m_low = 0; m_out = 0; m_first = 1'b1;
      end else m_renorm();
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_bin = b; in_state = 6'(s); in_mps = m;
    in_lps_row = row_of(s); in_lps_next = 6'(lnext(s));
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R10 ready after accept", int'(in_ready), 0);
    if (kind == 2'b00) begin
      chk(ctx_wr_valid == 1'b1, "R2 write strobe", int'(ctx_wr_valid), 1);
      chk(int'(ctx_wr_state) == ns, (b != m) ? "R3 lps state" : "R2 mps state", int'(ctx_wr_state), ns);
      chk(ctx_wr_mps == nm, (b != m) ? "R3 lps mps" : "R2 mps value", int'(ctx_wr_mps), int'(nm));
    end else begin
      chk(ctx_wr_valid == 1'b0, (kind == 2'b01) ? "R7 no ctx write" : "R8 no ctx write", int'(ctx_wr_valid), 0);
    end
  endtask

  task automatic seg_end(string tag);
    int ns; bit nm; int bad;
    send(2'b10, 1'b1, 0, 1'b0, ns, nm);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {tag, " bit count"}, got_q.size(), exp_q.size());
    bad = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    chk(bad < 0, {tag, " first mismatching bit index"}, bad, -1);
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s, ns, k, r;
    bit m, nm, b;
    int cs[4];
    bit cm[4];
    rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'b00; in_bin = 1'b0; in_state = '0;
    in_mps = 1'b0; in_lps_row = '0; in_lps_next = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 no bits in reset", int'(out_valid), 0);
    chk(ctx_wr_valid == 1'b0, "R1 no ctx write in reset", int'(ctx_wr_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 idle after reset", int'(in_ready), 1);

    s = 0; m = 1'b0;
    for (int i = 0; i < 70; i++) begin send(2'b00, m, s, m, ns, nm); s = ns; m = nm; end
    chk(s == 62, "R2 saturation reached", s, 62);
    seg_end("R2 R4 R6 mps run");

    for (int st = 0; st < 63; st++)
      for (int mv = 0; mv < 2; mv++)
        for (int bv = 0; bv < 2; bv++)
          send(2'b00, bit'(bv), st, bit'(mv), ns, nm);
    seg_end("R3 R4 R5 state sweep");

    for (int i = 0; i < 300; i++) send(2'b01, bit'($urandom_range(0, 1)), 0, 1'b0, ns, nm);
    for (int i = 0; i < 40; i++) send(2'b01, bit'(i % 2), 0, 1'b0, ns, nm);
    seg_end("R5 R6 R7 bypass");

    s = 10; m = 1'b1;
    for (int i = 0; i < 200; i++) begin
      k = $urandom_range(0, 2);
      if (k == 0) begin send(2'b00, bit'($urandom_range(0, 1)), s, m, ns, nm); s = ns; m = nm; end
      else if (k == 1) send(2'b01, bit'($urandom_range(0, 1)), 0, 1'b0, ns, nm);
      else send(2'b11, 1'b0, 0, 1'b0, ns, nm);
    end
    seg_end("R8 R9 terminate zero");

    for (int c = 0; c < 4; c++) begin cs[c] = 0; cm[c] = 1'b0; end
    for (int seg = 0; seg < 20; seg++) begin
      for (int i = 0; i < 150; i++) begin
        r = $urandom_range(0, 9);
        k = $urandom_range(0, 3);
        if (r < 6) begin
          b = ($urandom_range(0, 4) == 0) ? !cm[k] : cm[k];
          send(2'b00, b, cs[k], cm[k], ns, nm);
          cs[k] = ns; cm[k] = nm;
        end else if (r < 9) send(2'b01, bit'($urandom_range(0, 1)), 0, 1'b0, ns, nm);
        else send(2'b10, 1'b0, 0, 1'b0, ns, nm);
      end
      seg_end("R4 R5 R9 R11 random mix");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule